// File: doc/BRIEF.md
# Wake-Up and Halt Control Unit

This block holds the power-management control register of a bus device node and acts on it. It records wake-up events from two sources, activity seen on the bus and accesses made by the local microcontroller. Each source has its own enable and its own pending flag. The pending flags together drive one wake-up interrupt line. That line is raised either as soon as a flag is pending or only after a fixed wake-up delay, which a mode bit selects.

The same register controls a halt output. The node can be halted automatically when it enters the suspended state, if the halt-on-suspend bit is armed. Software can also force a halt, but only while the node is not attached. Any enabled wake event releases the halt. Software reaches the register through a single-cycle write port and a combinational read port.

Top module: `wake_halt_ctrl`

## Requirements
- R1: A synchronous active-low reset loads the register so that it reads 0x0F: force-halt (bit 7), halt-on-suspend (bit 6), wake mode (bit 5) and reserved (bit 4) are 0, microcontroller enable (bit 3) and bus enable (bit 2) are 1, and microcontroller pending (bit 1) and bus pending (bit 0) are 1. Reset also drives halt low and clears the delay timer.
- R2: Bit 4 always reads 0 and ignores writes. Bits 5, 3 and 2 read back the last value written, and a write takes effect at the next clock edge.
- R3: Writing 0 to bit 0 or bit 1 clears that pending flag. Writing 1 to either bit leaves the flag unchanged.
- R4: A bus-activity event while bit 2 is 1 sets bit 0 at the next edge, and a microcontroller-access event while bit 3 is 1 sets bit 1. With the enable at 0 the event has no effect. A set and a write-0 clear in the same cycle leave the flag set.
- R5: With wake mode 0, the interrupt output equals the OR of the two pending bits in the same cycle.
- R6: With wake mode 1, the interrupt is high only when a pending bit is set and the delay has expired. The first enabled event starts a timer that expires DELAY_CYCLES edges later. Later events do not restart it. The expiry is forgotten once both pending bits read 0.
- R7: With bit 6 set, a 0-to-1 change of the suspend input drives halt high at the next edge. A write of 1 to bit 6 while the suspend input is 1 is ignored, and the bit keeps its old value.
- R8: A write with bit 7 set while not attached stores 1 in bit 7 and drives halt high at the next edge. While attached, a 1 written to bit 7 is ignored: the bit and halt keep their values.
- R9: Any enabled wake event drives halt low at the next edge. This takes precedence over a halt request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Current register value |
| bus_act | input | 1 | Bus activity detected (one cycle per event) |
| mcu_acc | input | 1 | Microcontroller access detected |
| suspended | input | 1 | Node is in the suspended state |
| attached | input | 1 | Node is attached to the bus |
| halt | output | 1 | Node halted |
| wake_irq | output | 1 | Wake-up interrupt request |

## Verification
The hardest situations to reach are the collisions. One is a wake event in the same cycle as a write that clears its pending flag. Another is a wake event in the same cycle as a force-halt write. A third is a halt-on-suspend write arriving while the node is already suspended, which must be ignored. These are driven as directed cycles with the bench's per-cycle model checking every output. A long random phase then toggles suspend and attach rarely while writes and events fire often, so the delay timer is restarted, expires and is forgotten many times.

// File: rtl/wkh_pkg.sv
// Package: shared field positions and the decoded register view of the
// wake-up and halt control unit. Assumes an 8-bit register.
package wkh_pkg;
    localparam int REG_W   = 8;
    localparam int B_FHALT = 7;
    localparam int B_HOS   = 6;
    localparam int B_WMODE = 5;
    localparam int B_RSVD  = 4;
    localparam int B_EN_UC = 3;
    localparam int B_EN_BS = 2;
    localparam int B_PN_UC = 1;
    localparam int B_PN_BS = 0;

    typedef struct packed {
        logic force_halt;
        logic halt_on_susp;
        logic wake_mode;
        logic en_mcu;
        logic en_bus;
        logic pnd_mcu;
        logic pnd_bus;
    } wkh_ctrl_t;
endpackage

// File: rtl/wkh_regfile.sv
// Module: control register storage. Applies the write rules (clear-on-zero
// pending flags, conditionally ignored halt bits) and the event sets.
// Assumes qualified events arrive already gated by their enables.
module wkh_regfile
    import wkh_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             attached,
    input  logic             suspended,
    input  logic             q_bus,
    input  logic             q_mcu,
    output wkh_ctrl_t        ctrl,
    output logic [REG_W-1:0] rd_data
);
    wkh_ctrl_t ctrl_q;

    // Register update: reset values, guarded writes, then event sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{force_halt: 1'b0, halt_on_susp: 1'b0, wake_mode: 1'b0,
                        en_mcu: 1'b1, en_bus: 1'b1, pnd_mcu: 1'b1, pnd_bus: 1'b1};
        end else begin
            if (wr_en) begin
                if (!(wr_data[B_FHALT] && attached))
                    ctrl_q.force_halt <= wr_data[B_FHALT];
                if (!(wr_data[B_HOS] && suspended))
                    ctrl_q.halt_on_susp <= wr_data[B_HOS];
                ctrl_q.wake_mode <= wr_data[B_WMODE];
                ctrl_q.en_mcu    <= wr_data[B_EN_UC];
                ctrl_q.en_bus    <= wr_data[B_EN_BS];
            end
            ctrl_q.pnd_mcu <= q_mcu || (ctrl_q.pnd_mcu && !(wr_en && !wr_data[B_PN_UC]));
            ctrl_q.pnd_bus <= q_bus || (ctrl_q.pnd_bus && !(wr_en && !wr_data[B_PN_BS]));
        end
    end

    // Read view: reserved position forced to zero.
    always_comb begin
        rd_data          = '0;
        rd_data[B_FHALT] = ctrl_q.force_halt;
        rd_data[B_HOS]   = ctrl_q.halt_on_susp;
        rd_data[B_WMODE] = ctrl_q.wake_mode;
        rd_data[B_EN_UC] = ctrl_q.en_mcu;
        rd_data[B_EN_BS] = ctrl_q.en_bus;
        rd_data[B_PN_UC] = ctrl_q.pnd_mcu;
        rd_data[B_PN_BS] = ctrl_q.pnd_bus;
    end

    assign ctrl = ctrl_q;

    AST_PND_BUS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q.pnd_bus) |-> $past(q_bus)); // R4
    AST_PND_MCU_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q.pnd_mcu) |-> $past(q_mcu)); // R4
    AST_FH_ATTACHED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[B_FHALT] && attached) |=> $stable(ctrl_q.force_halt)); // R8
    AST_HOS_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[B_HOS] && suspended) |=> $stable(ctrl_q.halt_on_susp)); // R7
endmodule

// File: rtl/wkh_halt_ctl.sv
// Module: halt state. Sets on an accepted force-halt request or on the
// suspend rising edge with halt-on-suspend armed; a wake event clears it
// and wins over any set in the same cycle.
module wkh_halt_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_q,
    input  logic fh_req,
    input  logic hos,
    input  logic suspended,
    output logic halt
);
    logic susp_d;
    logic susp_rise;

    assign susp_rise = suspended && !susp_d;

    // Suspend edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) susp_d <= 1'b0;
        else        susp_d <= suspended;
    end

    // Halt state with wake taking precedence.
    always_ff @(posedge clk) begin
        if (!rst_n)                          halt <= 1'b0;
        else if (wake_q)                     halt <= 1'b0;
        else if (fh_req || (hos && susp_rise)) halt <= 1'b1;
    end

    AST_HALT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |=> !halt); // R9
    AST_HALT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt) |-> $past(fh_req || (hos && suspended))); // R7
endmodule

// File: rtl/wkh_delay.sv
// Module: wake-up delay timer. The first qualifying event starts a count
// of DELAY_CYCLES edges; expiry is held until no flag is pending.
module wkh_delay #(
    parameter int DELAY_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic any_pnd,
    output logic done
);
    localparam int CNT_W = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYCLES - 1);

    logic             run;
    logic [CNT_W-1:0] cnt;

    // Timer sequencing: start, count, expire, forget.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run  <= 1'b0;
            cnt  <= '0;
            done <= 1'b0;
        end else if (run) begin
            if (cnt == LAST) begin
                run  <= 1'b0;
                done <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (start && !done) begin
            run <= 1'b1;
            cnt <= '0;
        end else if (done && !any_pnd) begin
            done <= 1'b0;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= LAST)); // R6
    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(run)); // R6
endmodule

// File: rtl/wake_halt_ctrl.sv
// Module: top of the wake-up and halt control unit. Qualifies events with
// their enables, ties register, halt and delay logic together and forms
// the interrupt. Assumes event inputs are synchronous to clk.
module wake_halt_ctrl
    import wkh_pkg::*;
#(
    parameter int DELAY_CYCLES = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       bus_act,
    input  logic       mcu_acc,
    input  logic       suspended,
    input  logic       attached,
    output logic       halt,
    output logic       wake_irq
);
    wkh_ctrl_t ctrl;
    logic      q_bus, q_mcu, wake_q, fh_req, any_pnd, dly_done;

    assign q_bus   = bus_act && ctrl.en_bus;
    assign q_mcu   = mcu_acc && ctrl.en_mcu;
    assign wake_q  = q_bus || q_mcu;
    assign fh_req  = wr_en && wr_data[B_FHALT] && !attached;
    assign any_pnd = ctrl.pnd_bus || ctrl.pnd_mcu;

    wkh_regfile u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .attached(attached), .suspended(suspended),
        .q_bus(q_bus), .q_mcu(q_mcu), .ctrl(ctrl), .rd_data(rd_data)
    );

    wkh_halt_ctl u_halt (
        .clk(clk), .rst_n(rst_n), .wake_q(wake_q), .fh_req(fh_req),
        .hos(ctrl.halt_on_susp), .suspended(suspended), .halt(halt)
    );

    wkh_delay #(.DELAY_CYCLES(DELAY_CYCLES)) u_dly (
        .clk(clk), .rst_n(rst_n), .start(wake_q), .any_pnd(any_pnd),
        .done(dly_done)
    );

    // Interrupt: pending OR, gated by the delay when mode 1 is selected.
    always_comb begin
        wake_irq = any_pnd && (!ctrl.wake_mode || dly_done);
    end

    AST_IRQ_NEEDS_PND: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |-> (rd_data[B_PN_BS] || rd_data[B_PN_UC])); // R5
    AST_IRQ_MODE0: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[B_WMODE] && (rd_data[B_PN_BS] || rd_data[B_PN_UC])) |-> wake_irq); // R5
endmodule

// File: tb/wake_halt_ctrl_tb.sv
module wake_halt_ctrl_tb;
    localparam int D = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       bus_act = 1'b0, mcu_acc = 1'b0, suspended = 1'b0, attached = 1'b1;
    logic [7:0] rd_data;
    logic       halt, wake_irq;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit ended  = 1'b0;

    // bench model state
    bit m_fh, m_hos, m_wm, m_euc, m_ebs, m_puc, m_pbs, m_halt, m_run, m_done, m_susd;
    int m_cnt;

    always #2 clk = ~clk;

    wake_halt_ctrl #(.DELAY_CYCLES(D)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .bus_act(bus_act), .mcu_acc(mcu_acc),
        .suspended(suspended), .attached(attached), .halt(halt),
        .wake_irq(wake_irq)
    );

    function automatic logic [7:0] exp_rd();
        return {m_fh, m_hos, m_wm, 1'b0, m_euc, m_ebs, m_puc, m_pbs};
    endfunction

    function automatic bit exp_irq();
        return (m_puc || m_pbs) && (!m_wm || m_done);
    endfunction

    task automatic model_reset();
        m_fh = 0; m_hos = 0; m_wm = 0; m_euc = 1; m_ebs = 1; m_puc = 1; m_pbs = 1;
        m_halt = 0; m_run = 0; m_done = 0; m_susd = 0; m_cnt = 0;
    endtask

    task automatic model_step();
        bit qb, qu, q, any;
        qb = bus_act && m_ebs;
        qu = mcu_acc && m_euc;
        q  = qb || qu;
        any = m_pbs || m_puc;
        if (q) m_halt = 0;
        else if ((wr_en && wr_data[7] && !attached) || (m_hos && suspended && !m_susd)) m_halt = 1;
        if (m_run) begin
            if (m_cnt == D - 1) begin m_run = 0; m_done = 1; end
            else m_cnt++;
        end else if (q && !m_done) begin m_run = 1; m_cnt = 0; end
        else if (m_done && !any) m_done = 0;
        if (wr_en) begin
            if (!(wr_data[7] && attached)) m_fh = wr_data[7];
            if (!(wr_data[6] && suspended)) m_hos = wr_data[6];
            m_wm = wr_data[5]; m_euc = wr_data[3]; m_ebs = wr_data[2];
            m_puc = m_puc && wr_data[1];
            m_pbs = m_pbs && wr_data[0];
        end
        m_puc = m_puc || qu;
        m_pbs = m_pbs || qb;
        m_susd = suspended;
    endtask

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        check(rd_data == exp_rd(), tag, "rd_data", rd_data, exp_rd());
        check(halt == m_halt, tag, "halt", halt, m_halt);
        check(wake_irq == exp_irq(), tag, "wake_irq", wake_irq, exp_irq());
    endtask

    // One cycle: drive at negedge, model at posedge, compare at next negedge.
    task automatic cyc(bit we, logic [7:0] wd, bit ba, bit ma, bit sus, bit att, string tag);
        wr_en = we; wr_data = wd; bus_act = ba; mcu_acc = ma;
        suspended = sus; attached = att;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(int n, bit sus, bit att, string tag);
        for (int i = 0; i < n; i++) cyc(0, 8'h00, 0, 0, sus, att, tag);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000 && !ended) begin
                ended = 1;
                errors++; checks++;
                $display("FAIL watchdog: actual=%0d expected<200000 cycles", cycles);
                $display("  Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        bit sus, att;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");                       // register reads 0x0F, halt low
        check(rd_data == 8'h0F, "R1", "reset value", rd_data, 8'h0F);
        idle(1, 0, 1, "R1");

        // R2: reserved bit, field readback; R8 attached ignores force-halt
        cyc(1, 8'hFF, 0, 0, 0, 1, "R2");
        check(rd_data[4] == 1'b0, "R2", "reserved bit", rd_data[4], 0);
        // R3: clear by writing 0, writing 1 keeps 0
        cyc(1, 8'h0C, 0, 0, 0, 1, "R3");
        cyc(1, 8'h0F, 0, 0, 0, 1, "R3");
        check(rd_data[1:0] == 2'b00, "R3", "pending after write 1", rd_data[1:0], 0);
        // R4 / R5: enabled event sets pending, irq follows at once
        cyc(0, 8'h00, 1, 0, 0, 1, "R4");
        idle(1, 0, 1, "R5");
        cyc(1, 8'h08, 0, 0, 0, 1, "R3");
        cyc(0, 8'h00, 1, 0, 0, 1, "R4");     // disabled bus event
        check(rd_data[0] == 1'b0, "R4", "disabled event", rd_data[0], 0);
        cyc(1, 8'h08, 0, 1, 0, 1, "R4");     // set vs clear collision
        check(rd_data[1] == 1'b1, "R4", "set wins over clear", rd_data[1], 1);
        // R6: delayed interrupt
        cyc(1, 8'h2C, 0, 0, 0, 1, "R6");
        cyc(0, 8'h00, 1, 0, 0, 1, "R6");
        idle(D - 2, 0, 1, "R6");
        cyc(0, 8'h00, 0, 1, 0, 1, "R6");     // later event does not restart
        idle(3, 0, 1, "R6");
        check(wake_irq == 1'b1, "R6", "irq after delay", wake_irq, 1);
        cyc(1, 8'h2C, 0, 0, 0, 1, "R6");
        idle(2, 0, 1, "R6");
        // R7 / R9: halt on suspend and wake release
        cyc(1, 8'h4C, 0, 0, 0, 1, "R7");
        cyc(0, 8'h00, 0, 0, 1, 1, "R7");
        check(halt == 1'b1, "R7", "halt on suspend", halt, 1);
        cyc(0, 8'h00, 1, 0, 1, 1, "R9");
        check(halt == 1'b0, "R9", "wake clears halt", halt, 0);
        cyc(1, 8'h0C, 0, 0, 1, 1, "R7");
        cyc(1, 8'h4C, 0, 0, 1, 1, "R7");     // ignored while suspended
        check(rd_data[6] == 1'b0, "R7", "hos ignored", rd_data[6], 0);
        idle(1, 0, 1, "R7");
        idle(2, 1, 1, "R7");
        // R8 / R9: force halt
        cyc(1, 8'h8C, 0, 0, 0, 1, "R8");
        check(halt == 1'b0, "R8", "attached ignores", halt, 0);
        cyc(1, 8'h8C, 0, 0, 0, 0, "R8");
        check(halt == 1'b1, "R8", "force halt", halt, 1);
        cyc(1, 8'h0C, 0, 0, 0, 0, "R8");
        cyc(1, 8'h8C, 1, 0, 0, 0, "R9");     // wake wins
        check(halt == 1'b0, "R9", "wake precedence", halt, 0);

        // constrained random phase
        void'($urandom(32'h5eed_1234));
        sus = 0; att = 1;
        for (int i = 0; i < 4000; i++) begin
            bit we, ba, ma;
            logic [7:0] wd;
            if ($urandom_range(15) == 0) sus = !sus;
            if ($urandom_range(15) == 0) att = !att;
            we = ($urandom_range(3) == 0);
            wd = 8'($urandom());
            ba = ($urandom_range(7) == 0);
            ma = ($urandom_range(7) == 0);
            cyc(we, wd, ba, ma, sus, att, "R3");
        end

        if (!ended) begin
            ended = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule